// File: doc/BRIEF.md
# Masked Four-Line Priority Interrupt Unit

This block arbitrates among four peripheral interrupt lines. A one-cycle pulse on any request line sets a bit in a pending register. That bit stays set until the processor acknowledges that line by its index. A mask register, written by software, decides which pending bits may compete. A fixed-priority encoder picks the highest enabled pending line, with line 3 highest and line 0 lowest. It produces a two-bit index and an interrupt flag.

A vector generator adds the index, scaled to four-byte slots, to a programmable base address. The result is the entry address of the service routine. The flag, index and vector are combinational functions of the registered pending bits, the mask and the base. They therefore settle within the same cycle in which those registers change.

Software writes the mask and the base through one register write port, choosing the target with a select bit. The processor services the line named by the index and then pulses the acknowledge input with that index. Reset is asynchronous and active low. Its release is synchronised inside the block, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `pint_unit`

## Requirements
- R1: A high level on `req_i[k]` at a rising clock edge sets pending bit k. Only an acknowledge for line k clears that bit again.
- R2: `ack_i` high with `ack_idx_i` = k at a clock edge clears pending bit k and leaves the other bits untouched. If `req_i[k]` is high at the same edge, bit k stays set.
- R3: A line competes only if its pending bit and its mask bit are both 1. A pending line whose mask bit is 0 neither raises `irq_o` nor affects `irq_idx_o`.
- R4: When `irq_o` is 1, `irq_idx_o` is the binary index of the highest-numbered competing line (priority 3 > 2 > 1 > 0). With pending 0111 and mask 1011, the index is 01.
- R5: `irq_o` is the OR of all competing lines. When `irq_o` is 0, `irq_idx_o` is 00.
- R6: After reset, the pending bits, the mask and the base are all zero. Outputs then read `irq_o`=0, `irq_idx_o`=00 and `vec_addr_o`=0.
- R7: `wr_en_i` high at a clock edge writes the register chosen by `wr_sel_i`. A select of 0 loads the mask from `wr_data_i[3:0]`, with bit k enabling line k. A select of 1 loads the base from all of `wr_data_i`. The new value affects the outputs from the following cycle.
- R8: `vec_addr_o` equals base + 4 × `irq_idx_o`, taken modulo 2^16.
- R9: Clearing a mask bit does not clear the pending bit. Setting the mask bit again makes the line compete once more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 4 | Request lines; a high level at an edge sets the pending bit |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 mask, 1 vector base |
| wr_data_i | input | 16 | Write data |
| ack_i | input | 1 | Acknowledge strobe |
| ack_idx_i | input | 2 | Index of the line being acknowledged |
| irq_o | output | 1 | Interrupt flag |
| irq_idx_o | output | 2 | Index of the winning line |
| vec_addr_o | output | 16 | Service routine vector address |

## Verification
The bench targets several corner cases, each tied to a specific wrong design:
- A request and an acknowledge for the same line at the same edge. A design that lets the clear win would drop that request.
- A pending line that is masked and later unmasked. A design that clears pending bits when the mask falls would never raise the interrupt again.
- The worked example with pending 0111 and mask 1011. An encoder that ignored the mask would report index 2 here instead of 1.
- A base near the top of the address space with index 3. A vector adder that is too narrow or misaligned would not wrap to the expected low address.
- An idle flag. A design that leaves a stale index when the flag is 0 would show a non-zero index.

// File: rtl/pint_pkg.sv
package pint_pkg;
  localparam int NUM_LINES = 4;
  localparam int ADDR_W    = 16;
  localparam int SLOT_SH   = 2;

  typedef enum logic {
    SEL_MASK = 1'b0,
    SEL_BASE = 1'b1
  } wr_sel_e;
endpackage

// File: rtl/pint_pending.sv
module pint_pending #(
  parameter int NUM_LINES = 4,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] req_i,
  input  logic                 ack_i,
  input  logic [IDX_W-1:0]     ack_idx_i,
  output logic [NUM_LINES-1:0] pend_o
);
  logic [NUM_LINES-1:0] pend_d, pend_q;

  always_comb begin
    pend_d = pend_q;
    if (ack_i) pend_d[ack_idx_i] = 1'b0;
    pend_d = pend_d | req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_chk
    AST_REQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      req_i[k] |=> pend_q[k]); // R1
    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_i[k] && !(ack_i && ack_idx_i == IDX_W'(k))) |=> $stable(pend_q[k])); // R1
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && ack_idx_i == IDX_W'(k) && !req_i[k]) |=> !pend_q[k]); // R2
  end
endmodule

// File: rtl/pint_regs.sv
module pint_regs
  import pint_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int ADDR_W    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en_i,
  input  logic                 wr_sel_i,
  input  logic [ADDR_W-1:0]    wr_data_i,
  output logic [NUM_LINES-1:0] mask_o,
  output logic [ADDR_W-1:0]    base_o
);
  logic                 mask_we, base_we;
  logic [NUM_LINES-1:0] mask_q;
  logic [ADDR_W-1:0]    base_q;

  always_comb begin
    mask_we = wr_en_i && (wr_sel_e'(wr_sel_i) == SEL_MASK);
    base_we = wr_en_i && (wr_sel_e'(wr_sel_i) == SEL_BASE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= wr_data_i[NUM_LINES-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_we) base_q <= wr_data_i;
  end

  assign mask_o = mask_q;
  assign base_o = base_q;

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_sel_i) |=> mask_q == $past(wr_data_i[NUM_LINES-1:0])); // R7
  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && !wr_sel_i) |=> $stable(mask_q)); // R7
endmodule

// File: rtl/pint_encode.sv
module pint_encode #(
  parameter int NUM_LINES = 4,
  parameter int ADDR_W    = 16,
  parameter int SLOT_SH   = 2,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] pend_i,
  input  logic [NUM_LINES-1:0] mask_i,
  input  logic [ADDR_W-1:0]    base_i,
  output logic                 irq_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic [ADDR_W-1:0]    vec_o
);
  logic [NUM_LINES-1:0] eff;

  always_comb begin
    eff   = pend_i & mask_i;
    irq_o = |eff;
    idx_o = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (eff[i]) idx_o = i[IDX_W-1:0];
    end
    vec_o = base_i + (ADDR_W'(idx_o) << SLOT_SH);
  end

  AST_IDLE_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> idx_o == '0); // R5
  AST_WINNER_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (eff >> idx_o) == NUM_LINES'(1)); // R4
  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (mask_i[idx_o] && pend_i[idx_o])); // R3
endmodule

// File: rtl/pint_unit.sv
module pint_unit
  import pint_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_LINES-1:0]          req_i,
  input  logic                          wr_en_i,
  input  logic                          wr_sel_i,
  input  logic [ADDR_W-1:0]             wr_data_i,
  input  logic                          ack_i,
  input  logic [$clog2(NUM_LINES)-1:0]  ack_idx_i,
  output logic                          irq_o,
  output logic [$clog2(NUM_LINES)-1:0]  irq_idx_o,
  output logic [ADDR_W-1:0]             vec_addr_o
);
  logic                 rst_meta, rst_sync;
  logic [NUM_LINES-1:0] pend, mask;
  logic [ADDR_W-1:0]    base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  pint_pending #(.NUM_LINES(NUM_LINES)) u_pending (
    .clk       (clk),
    .rst_n     (rst_sync),
    .req_i     (req_i),
    .ack_i     (ack_i),
    .ack_idx_i (ack_idx_i),
    .pend_o    (pend)
  );

  pint_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .mask_o    (mask),
    .base_o    (base)
  );

  pint_encode #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .SLOT_SH(SLOT_SH)) u_encode (
    .clk    (clk),
    .rst_n  (rst_sync),
    .pend_i (pend),
    .mask_i (mask),
    .base_i (base),
    .irq_o  (irq_o),
    .idx_o  (irq_idx_o),
    .vec_o  (vec_addr_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync |-> (!irq_o && vec_addr_o == '0)); // R6
endmodule

// File: tb/test_pint_unit.sv
module test_pint_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  req;
  logic        wen, wsel, ack;
  logic [15:0] wdata;
  logic [1:0]  aidx;
  logic        irq;
  logic [1:0]  idx;
  logic [15:0] vec;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;
  int cyc_cnt = 0;

  logic [3:0]  m_pend, m_mask;
  logic [15:0] m_base;

  always #5 clk = ~clk;

  pint_unit i_pint_unit (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wr_en_i(wen), .wr_sel_i(wsel),
    .wr_data_i(wdata), .ack_i(ack), .ack_idx_i(aidx),
    .irq_o(irq), .irq_idx_o(idx), .vec_addr_o(vec)
  );

  function automatic logic [1:0] exp_idx(logic [3:0] e);
    logic [1:0] r = 2'd0;
    for (int i = 0; i < 4; i++) if (e[i]) r = 2'(i);
    return r;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    logic [3:0] e = m_pend & m_mask;
    chk({tag, " R5 irq"}, 16'(irq), 16'(|e));
    chk({tag, " R4 idx"}, 16'(idx), 16'(exp_idx(e)));
    chk({tag, " R8 vec"}, vec, m_base + (16'(exp_idx(e)) << 2));
  endtask

  task automatic cyc(logic [3:0] r, logic we, logic ws, logic [15:0] wd,
                     logic a, logic [1:0] ai, string tag);
    req = r; wen = we; wsel = ws; wdata = wd; ack = a; aidx = ai;
    if (a) m_pend[ai] = 1'b0;
    m_pend = m_pend | r;
    if (we && !ws) m_mask = wd[3:0];
    if (we && ws)  m_base = wd;
    @(posedge clk);
    @(negedge clk);
    req = '0; wen = 0; ack = 0;
    check_all(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 200000) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    req = '0; wen = 0; wsel = 0; wdata = '0; ack = 0; aidx = '0;
    m_pend = '0; m_mask = '0; m_base = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R6 reset irq", 16'(irq), 16'd0);
    chk("R6 reset idx", 16'(idx), 16'd0);
    chk("R6 reset vec", vec, 16'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R6: mask is zero after reset, so requests stay silent
    cyc(4'b1111, 0, 0, 16'h0, 0, 2'd0, "R6 R3 mask zero");
    chk("R6 R3 no irq", 16'(irq), 16'd0);
    // R7: base then mask write; doc example pending 0111 mask 1011
    cyc(4'b0000, 1, 1, 16'h1000, 0, 2'd0, "R7 base");
    cyc(4'b0000, 1, 0, 16'h0000, 0, 2'd0, "R7 clear");
    cyc(4'b0000, 0, 0, 16'h0, 1, 2'd3, "R2 ack3");
    cyc(4'b0000, 1, 0, 16'h000B, 0, 2'd0, "R7 mask");
    chk("R4 example idx", 16'(idx), 16'd1);
    chk("R8 example vec", vec, 16'h1004);
    // R9: pending 2 held while masked, then unmasked
    cyc(4'b0000, 1, 0, 16'h000F, 0, 2'd0, "R9 unmask");
    chk("R9 line2 back", 16'(idx), 16'd2);
    // R1: pending holds without ack
    cyc(4'b0000, 0, 0, 16'h0, 0, 2'd0, "R1 hold");
    chk("R1 still idx2", 16'(idx), 16'd2);
    // R2: ack and request on same line keeps it set
    cyc(4'b0100, 0, 0, 16'h0, 1, 2'd2, "R2 ack+req");
    chk("R2 kept", 16'(idx), 16'd2);
    cyc(4'b0000, 0, 0, 16'h0, 1, 2'd2, "R2 ack2");
    chk("R2 cleared idx", 16'(idx), 16'd1);
    // R8 wrap: base near top with line 3
    cyc(4'b1000, 1, 1, 16'hFFFC, 0, 2'd0, "R8 wrap");
    chk("R8 wrap vec", vec, 16'h0008);
    // R5: drain all lines
    for (int k = 0; k < 4; k++) cyc(4'b0000, 0, 0, 16'h0, 1, 2'(k), "R5 drain");
    chk("R5 idle idx", 16'(idx), 16'd0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [3:0]  r  = 4'($urandom) & 4'($urandom) & 4'($urandom);
      logic        we = ($urandom % 8) == 0;
      logic        ws = 1'($urandom);
      logic [15:0] wd = 16'($urandom);
      logic        a  = ($urandom % 3) == 0;
      logic [1:0]  ai = 2'($urandom);
      cyc(r, we, ws, wd, a, ai, "R1 R2 R3 R7 R9 random");
    end
    finish_run();
  end
endmodule